// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block tracks instructions that an out-of-order core has dispatched but not yet retired. Each dispatched instruction claims the next free slot of a circular buffer, and the slot index goes back to the issuer as the rename tag for that instruction's result. Execution units later post results on a single result bus, addressed by tag. Results can arrive in any order. The buffer retires them strictly in dispatch order from the oldest slot. A retiring instruction either writes the architectural register file or releases a store to memory.

While an instruction waits to retire, any consumer can look up its tag and obtain the result as soon as that result exists. A result posted in the same cycle as the lookup is forwarded straight through. Faults stay in the faulting slot until that slot becomes the oldest. A fault at the oldest slot, or a branch at the oldest slot that was resolved as mispredicted, discards every slot in one cycle. A mispredicted branch also emits a redirect to the corrected target.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: `iss_ready` is 1, `iss_tag` is 0, `lk_done` is 0, and no retire, flush, fault or redirect output is active.
- R2: Tags are handed out in sequence 0,1,...,DEPTH-1,0,... with one tag per accepted dispatch (`iss_valid` and `iss_ready` both high). `iss_ready` is 0 while DEPTH instructions are outstanding.
- R3: A result whose tag names an occupied slot that is still waiting marks that slot done and stores its value, auxiliary word and flags. A result aimed at a free slot, or at a slot that is already done, changes nothing.
- R4: Only the oldest slot retires, and only once it is done. Younger done slots wait, and retirement follows dispatch order.
- R5: Kind encoding is 2'b00 register op, 2'b01 store, 2'b10 branch. A retiring register op drives `cm_reg_we` with its destination and value. A retiring store drives `cm_st_we` with address = auxiliary word and data = value. A correctly predicted branch retires with no write. At most one of the retire, fault and redirect outputs is active in a cycle.
- R6: A lookup of an occupied, done slot returns done and its value. A lookup of an occupied slot whose result is on the bus in that cycle returns done and the bus value. Any other lookup returns not-done.
- R7: A fault flag posted with a result has no effect until that slot is the oldest. It then raises `exc_valid` and `flush`, and the slot writes neither a register nor memory.
- R8: A branch posted with the mispredict flag raises `redir_valid` and `flush` when it is the oldest slot. `redir_pc` equals the auxiliary word posted with its result.
- R9: In a flush cycle `iss_ready` is 0 and any result posted is ignored. On the next cycle the buffer is empty and the next tag is 0.
- R10: A dispatch and a retirement in the same cycle both take effect, leaving the occupancy unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Dispatch request |
| iss_kind | input | 2 | Instruction kind (00 reg op, 01 store, 10 branch) |
| iss_dst | input | REG_W | Destination register (used by reg ops only) |
| iss_ready | output | 1 | A free slot exists and no flush is in progress |
| iss_tag | output | TAG_W | Tag given to a dispatch accepted this cycle |
| wb_valid | input | 1 | Result bus valid |
| wb_tag | input | TAG_W | Slot addressed by the result |
| wb_value | input | XLEN | Result value (store data for stores) |
| wb_aux | input | XLEN | Store address or resolved branch target |
| wb_exc | input | 1 | Instruction faulted |
| wb_mispred | input | 1 | Branch was mispredicted |
| lk_tag | input | TAG_W | Operand lookup tag |
| lk_done | output | 1 | Looked-up result is available |
| lk_value | output | XLEN | Looked-up result |
| cm_reg_we | output | 1 | Register file write at retirement |
| cm_reg_idx | output | REG_W | Register written |
| cm_reg_data | output | XLEN | Data written |
| cm_st_we | output | 1 | Store released to memory |
| cm_st_addr | output | XLEN | Store address |
| cm_st_data | output | XLEN | Store data |
| flush | output | 1 | All slots discarded at the next edge |
| exc_valid | output | 1 | Fault taken at the oldest slot |
| redir_valid | output | 1 | Mispredicted branch redirect |
| redir_pc | output | XLEN | Corrected fetch target |

## Verification
The properties assume that every input is known once reset is released, that dispatch and result inputs stay low during reset, and that the consumer treats `iss_tag` as valid only in a cycle where `iss_ready` is high. They do not assume that results target live slots. The stimulus deliberately posts results to free slots, to already-done slots and during flush cycles, so the design's own filtering is what the properties rely on. Directed sequences hold a fault behind an older instruction, hit the full-buffer and flush-cycle corners, and keep dispatch and retirement running in the same cycle. A long stretch of random dispatch, result and lookup traffic then runs against a queue-based model.

// File: rtl/rob_pkg.sv
package rob_pkg;
  localparam int XLEN  = 32;
  localparam int REG_W = 5;

  typedef enum logic [1:0] {
    K_REG    = 2'b00,
    K_STORE  = 2'b01,
    K_BRANCH = 2'b10
  } op_kind_e;

  // snapshot of one slot, used for the oldest-entry decision
  typedef struct packed {
    logic             busy;
    logic             done;
    op_kind_e         kind;
    logic [REG_W-1:0] dst;
    logic [XLEN-1:0]  value;
    logic [XLEN-1:0]  aux;
    logic             exc;
    logic             mis;
  } rob_slot_t;
endpackage

// File: rtl/rob_ptrs.sv
module rob_ptrs #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  output logic [TAG_W-1:0] head,
  output logic [TAG_W-1:0] tail,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  logic [TAG_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (flush) begin
      head_d = '0;
      tail_d = '0;
      cnt_d  = '0;
    end else begin
      if (pop)  head_d = (head_q == LAST) ? '0 : head_q + 1'b1;
      if (push) tail_d = (tail_q == LAST) ? '0 : tail_q + 1'b1;
      cnt_d = cnt_q + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign upd = flush | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  assign head  = head_q;
  assign tail  = tail_q;
  assign count = cnt_q;
  assign full  = (cnt_q == CNT_W'(DEPTH));
endmodule

// File: rtl/rob_slots.sv
module rob_slots
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             alloc_en,
  input  logic [TAG_W-1:0] alloc_tag,
  input  op_kind_e         alloc_kind,
  input  logic [REG_W-1:0] alloc_dst,
  input  logic             wb_en,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  input  logic [XLEN-1:0]  wb_aux,
  input  logic             wb_exc,
  input  logic             wb_mis,
  input  logic             free_en,
  input  logic [TAG_W-1:0] free_tag,
  output logic [DEPTH-1:0] busy_o,
  output logic [DEPTH-1:0] done_o,
  output logic [DEPTH-1:0] exc_o,
  output logic [DEPTH-1:0] mis_o,
  output op_kind_e         kind_o  [DEPTH],
  output logic [REG_W-1:0] dst_o   [DEPTH],
  output logic [XLEN-1:0]  value_o [DEPTH],
  output logic [XLEN-1:0]  aux_o   [DEPTH]
);
  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic             busy_q, busy_d, done_q, done_d;
    logic             here_alloc, here_free, here_wb, ctl_en;
    op_kind_e         kind_q;
    logic [REG_W-1:0] dst_q;
    logic [XLEN-1:0]  val_q, aux_q;
    logic             exc_q, mis_q;

    assign here_alloc = alloc_en && (alloc_tag == TAG_W'(i));
    assign here_free  = free_en  && (free_tag  == TAG_W'(i));
    assign here_wb    = wb_en && (wb_tag == TAG_W'(i)) && busy_q && !done_q;

    always_comb begin
      busy_d = busy_q;
      done_d = done_q;
      if (flush) begin
        busy_d = 1'b0;
        done_d = 1'b0;
      end else if (here_alloc) begin
        busy_d = 1'b1;
        done_d = 1'b0;
      end else if (here_free) begin
        busy_d = 1'b0;
        done_d = 1'b0;
      end else if (here_wb) begin
        done_d = 1'b1;
      end
    end

    assign ctl_en = flush | here_alloc | here_free | here_wb;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        busy_q <= 1'b0;
        done_q <= 1'b0;
      end else if (ctl_en) begin
        busy_q <= busy_d;
        done_q <= done_d;
      end
    end

    // payload carries no reset: it is only read while busy and done
    always_ff @(posedge clk) begin
      if (here_alloc && !flush) begin
        kind_q <= alloc_kind;
        dst_q  <= alloc_dst;
      end
      if (here_wb && !flush) begin
        val_q <= wb_value;
        aux_q <= wb_aux;
        exc_q <= wb_exc;
        mis_q <= wb_mis;
      end
    end

    assign busy_o[i]  = busy_q;
    assign done_o[i]  = done_q;
    assign exc_o[i]   = exc_q;
    assign mis_o[i]   = mis_q;
    assign kind_o[i]  = kind_q;
    assign dst_o[i]   = dst_q;
    assign value_o[i] = val_q;
    assign aux_o[i]   = aux_q;
  end
endmodule

// File: rtl/rob_fwd.sv
module rob_fwd
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy_i,
  input  logic [DEPTH-1:0] done_i,
  input  logic [XLEN-1:0]  value_i [DEPTH],
  input  logic             wb_en,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_done,
  output logic [XLEN-1:0]  lk_value
);
  logic sel_busy, sel_done, bus_hit;

  assign sel_busy = busy_i[lk_tag];
  assign sel_done = done_i[lk_tag];
  assign bus_hit  = wb_en && (wb_tag == lk_tag);

  always_comb begin
    lk_done  = 1'b0;
    lk_value = value_i[lk_tag];
    if (sel_busy && sel_done) begin
      lk_done = 1'b1;
    end else if (sel_busy && bus_hit) begin
      lk_done  = 1'b1;
      lk_value = wb_value;
    end
  end
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
(
  input  rob_slot_t        head_s,
  output logic             pop,
  output logic             flush,
  output logic             reg_we,
  output logic [REG_W-1:0] reg_idx,
  output logic [XLEN-1:0]  reg_data,
  output logic             st_we,
  output logic [XLEN-1:0]  st_addr,
  output logic [XLEN-1:0]  st_data,
  output logic             exc_valid,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc
);
  logic ripe;

  always_comb begin
    ripe        = head_s.busy && head_s.done;
    exc_valid   = ripe && head_s.exc;
    redir_valid = ripe && !head_s.exc && (head_s.kind == K_BRANCH) && head_s.mis;
    flush       = exc_valid || redir_valid;
    pop         = ripe && !flush;
    reg_we      = pop && (head_s.kind == K_REG);
    st_we       = pop && (head_s.kind == K_STORE);
  end

  assign reg_idx  = head_s.dst;
  assign reg_data = head_s.value;
  assign st_addr  = head_s.aux;
  assign st_data  = head_s.value;
  assign redir_pc = head_s.aux;
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [1:0]       iss_kind,
  input  logic [REG_W-1:0] iss_dst,
  output logic             iss_ready,
  output logic [TAG_W-1:0] iss_tag,
  input  logic             wb_valid,
  input  logic [TAG_W-1:0] wb_tag,
  input  logic [XLEN-1:0]  wb_value,
  input  logic [XLEN-1:0]  wb_aux,
  input  logic             wb_exc,
  input  logic             wb_mispred,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_done,
  output logic [XLEN-1:0]  lk_value,
  output logic             cm_reg_we,
  output logic [REG_W-1:0] cm_reg_idx,
  output logic [XLEN-1:0]  cm_reg_data,
  output logic             cm_st_we,
  output logic [XLEN-1:0]  cm_st_addr,
  output logic [XLEN-1:0]  cm_st_data,
  output logic             flush,
  output logic             exc_valid,
  output logic             redir_valid,
  output logic [XLEN-1:0]  redir_pc
);
  logic [TAG_W-1:0] head, tail;
  logic [CNT_W-1:0] occ_cnt;
  logic             full, do_issue, do_commit, wb_en;

  logic [DEPTH-1:0] s_busy, s_done, s_exc, s_mis;
  op_kind_e         s_kind  [DEPTH];
  logic [REG_W-1:0] s_dst   [DEPTH];
  logic [XLEN-1:0]  s_val   [DEPTH];
  logic [XLEN-1:0]  s_aux   [DEPTH];
  rob_slot_t        head_s;

  assign iss_ready = !full && !flush;
  assign do_issue  = iss_valid && iss_ready;
  assign iss_tag   = tail;
  assign wb_en     = wb_valid && !flush;

  rob_ptrs #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_ptrs (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (flush),
    .push  (do_issue),
    .pop   (do_commit),
    .head  (head),
    .tail  (tail),
    .count (occ_cnt),
    .full  (full)
  );

  rob_slots #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_slots (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (flush),
    .alloc_en   (do_issue),
    .alloc_tag  (tail),
    .alloc_kind (op_kind_e'(iss_kind)),
    .alloc_dst  (iss_dst),
    .wb_en      (wb_en),
    .wb_tag     (wb_tag),
    .wb_value   (wb_value),
    .wb_aux     (wb_aux),
    .wb_exc     (wb_exc),
    .wb_mis     (wb_mispred),
    .free_en    (do_commit),
    .free_tag   (head),
    .busy_o     (s_busy),
    .done_o     (s_done),
    .exc_o      (s_exc),
    .mis_o      (s_mis),
    .kind_o     (s_kind),
    .dst_o      (s_dst),
    .value_o    (s_val),
    .aux_o      (s_aux)
  );

  rob_fwd #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_fwd (
    .busy_i   (s_busy),
    .done_i   (s_done),
    .value_i  (s_val),
    .wb_en    (wb_en),
    .wb_tag   (wb_tag),
    .wb_value (wb_value),
    .lk_tag   (lk_tag),
    .lk_done  (lk_done),
    .lk_value (lk_value)
  );

  always_comb begin
    head_s.busy  = s_busy[head];
    head_s.done  = s_done[head];
    head_s.kind  = s_kind[head];
    head_s.dst   = s_dst[head];
    head_s.value = s_val[head];
    head_s.aux   = s_aux[head];
    head_s.exc   = s_exc[head];
    head_s.mis   = s_mis[head];
  end

  rob_retire u_retire (
    .head_s      (head_s),
    .pop         (do_commit),
    .flush       (flush),
    .reg_we      (cm_reg_we),
    .reg_idx     (cm_reg_idx),
    .reg_data    (cm_reg_data),
    .st_we       (cm_st_we),
    .st_addr     (cm_st_addr),
    .st_data     (cm_st_data),
    .exc_valid   (exc_valid),
    .redir_valid (redir_valid),
    .redir_pc    (redir_pc)
  );
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int DEPTH = 8,
  parameter int TAG_W = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iss_ready,
  input logic [TAG_W-1:0] iss_tag,
  input logic             flush,
  input logic             exc_valid,
  input logic             redir_valid,
  input logic             cm_reg_we,
  input logic             cm_st_we,
  input logic [CNT_W-1:0] count,
  input logic             do_issue,
  input logic             do_commit
);
  localparam logic [TAG_W-1:0] LAST = TAG_W'(DEPTH - 1);

  p_tag_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    do_issue |=> (iss_tag == (($past(iss_tag) == LAST) ? '0 : $past(iss_tag) + 1'b1)));

  p_empty_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !(cm_reg_we || cm_st_we || flush));

  p_single_action_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cm_reg_we, cm_st_we, exc_valid, redir_valid}));

  p_fault_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (flush && !cm_reg_we && !cm_st_we));

  p_redirect_flushes_r8: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> flush);

  p_flush_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !iss_ready);

  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0 && iss_tag == '0));

  p_occupancy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |=> (int'(count) == int'($past(count)) + int'($past(do_issue)) - int'($past(do_commit))));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .iss_ready   (iss_ready),
  .iss_tag     (iss_tag),
  .flush       (flush),
  .exc_valid   (exc_valid),
  .redir_valid (redir_valid),
  .cm_reg_we   (cm_reg_we),
  .cm_st_we    (cm_st_we),
  .count       (occ_cnt),
  .do_issue    (do_issue),
  .do_commit   (do_commit)
);

// File: tb/rob_core_test.sv
module rob_core_test;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk, rst_n;
  logic        iss_valid;
  logic [1:0]  iss_kind;
  logic [4:0]  iss_dst;
  logic        iss_ready;
  logic [2:0]  iss_tag;
  logic        wb_valid;
  logic [2:0]  wb_tag;
  logic [31:0] wb_value, wb_aux;
  logic        wb_exc, wb_mispred;
  logic [2:0]  lk_tag;
  logic        lk_done;
  logic [31:0] lk_value;
  logic        cm_reg_we;
  logic [4:0]  cm_reg_idx;
  logic [31:0] cm_reg_data;
  logic        cm_st_we;
  logic [31:0] cm_st_addr, cm_st_data;
  logic        flush, exc_valid, redir_valid;
  logic [31:0] redir_pc;

  rob_core #(.DEPTH(DEPTH)) uut (.*);

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;

  // reference model: program-order queue of tags plus per-tag records
  int          order_q[$];
  bit          m_busy[DEPTH];
  bit          m_done[DEPTH];
  int          m_kind[DEPTH];
  int          m_dst[DEPTH];
  logic [31:0] m_val[DEPTH];
  logic [31:0] m_aux[DEPTH];
  bit          m_exc[DEPTH];
  bit          m_mis[DEPTH];
  int          m_next = 0;

  task automatic finish_up();
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, check before posedge, update model, advance
  task automatic run(input bit iv, input int k, input int d,
                     input bit wv, input int wt, input logic [31:0] wval, input logic [31:0] waux,
                     input bit we, input bit wm, input int lt, input string lreq);
    int hd;
    bit ripe, e_exc, e_red, e_flush, e_go, e_rdy, e_lk;
    logic [31:0] e_lkv;
    iss_valid = iv; iss_kind = 2'(k); iss_dst = 5'(d);
    wb_valid = wv; wb_tag = 3'(wt); wb_value = wval; wb_aux = waux;
    wb_exc = we; wb_mispred = wm; lk_tag = 3'(lt);
    #1;
    hd = (order_q.size() > 0) ? order_q[0] : -1;
    ripe = (hd >= 0) && m_done[hd];
    e_exc = ripe && m_exc[hd];
    e_red = ripe && !m_exc[hd] && (m_kind[hd] == 2) && m_mis[hd];
    e_flush = e_exc || e_red;
    e_go = ripe && !e_flush;
    e_rdy = (order_q.size() < DEPTH) && !e_flush;
    e_lk = 0; e_lkv = '0;
    if (m_busy[lt] && m_done[lt]) begin e_lk = 1; e_lkv = m_val[lt]; end
    else if (m_busy[lt] && wv && !e_flush && wt == lt) begin e_lk = 1; e_lkv = wval; end

    chk("R2", "iss_ready", iss_ready, e_rdy);
    chk("R2 R10", "iss_tag", iss_tag, m_next);
    chk(lreq, "lk_done", lk_done, e_lk);
    if (e_lk) chk(lreq, "lk_value", lk_value, e_lkv);
    chk("R4", "cm_reg_we", cm_reg_we, e_go && m_kind[hd] == 0);
    if (e_go && m_kind[hd] == 0) begin
      chk("R5", "cm_reg_idx", cm_reg_idx, m_dst[hd]);
      chk("R5", "cm_reg_data", cm_reg_data, m_val[hd]);
    end
    chk("R4", "cm_st_we", cm_st_we, e_go && m_kind[hd] == 1);
    if (e_go && m_kind[hd] == 1) begin
      chk("R5", "cm_st_addr", cm_st_addr, m_aux[hd]);
      chk("R5", "cm_st_data", cm_st_data, m_val[hd]);
    end
    chk("R7", "exc_valid", exc_valid, e_exc);
    chk("R8", "redir_valid", redir_valid, e_red);
    if (e_red) chk("R8", "redir_pc", redir_pc, m_aux[hd]);
    chk("R9", "flush", flush, e_flush);

    if (e_flush) begin
      order_q.delete();
      m_next = 0;
      for (int i = 0; i < DEPTH; i++) begin m_busy[i] = 0; m_done[i] = 0; end
    end else begin
      if (wv && m_busy[wt] && !m_done[wt]) begin  // R3 filtering
        m_done[wt] = 1; m_val[wt] = wval; m_aux[wt] = waux; m_exc[wt] = we; m_mis[wt] = wm;
      end
      if (e_go) begin
        m_busy[hd] = 0; m_done[hd] = 0;
        void'(order_q.pop_front());
      end
      if (iv && e_rdy) begin
        m_busy[m_next] = 1; m_done[m_next] = 0; m_kind[m_next] = k; m_dst[m_next] = d;
        order_q.push_back(m_next);
        m_next = (m_next + 1) % DEPTH;
      end
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) run(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic iss(input int k, input int d);
    run(1, k, d, 0, 0, 0, 0, 0, 0, 0, "R6");
  endtask

  task automatic post(input int t, input logic [31:0] v, input logic [31:0] a, input bit e, input bit m);
    run(0, 0, 0, 1, t, v, a, e, m, 0, "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_busy[i] = 0; m_done[i] = 0; end
    rst_n = 0;
    iss_valid = 0; iss_kind = 0; iss_dst = 0; wb_valid = 0; wb_tag = 0;
    wb_value = 0; wb_aux = 0; wb_exc = 0; wb_mispred = 0; lk_tag = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    chk("R1", "iss_ready", iss_ready, 1);
    chk("R1", "iss_tag", iss_tag, 0);
    chk("R1", "lk_done", lk_done, 0);
    chk("R1", "retire outputs", {cm_reg_we, cm_st_we, flush, exc_valid, redir_valid}, 0);
    @(negedge clk);

    // R4 out-of-order results, in-order retirement; R6 same-cycle forward
    iss(0, 3); iss(0, 4); iss(0, 5);
    post(2, 32'h22, 0, 0, 0);
    run(0, 0, 0, 1, 0, 32'h10, 0, 0, 0, 2, "R6");
    run(0, 0, 0, 1, 1, 32'h11, 0, 0, 0, 1, "R6");
    idle(4);

    // R2 fill to DEPTH and try one more
    for (int i = 0; i < DEPTH + 1; i++) iss(0, i + 8);
    for (int i = 0; i < DEPTH; i++) run(0, 0, 0, 1, 7 - i, 32'h100 + i, 0, 0, 0, i, "R6");
    idle(10);

    // R3 result to a free slot is dropped; the slot stays not-done once reused
    run(0, 0, 0, 1, 6, 32'hdead, 0, 0, 0, 6, "R3");
    for (int i = 0; i < DEPTH; i++) run(1, 0, 1, 0, 0, 0, 0, 0, 0, 6, "R3");
    run(0, 0, 0, 1, 6, 32'h66, 0, 0, 0, 6, "R3");
    run(0, 0, 0, 1, 6, 32'h77, 0, 0, 0, 6, "R3");
    for (int i = 0; i < DEPTH; i++) post(i, 32'h200 + i, 0, 0, 0);
    idle(10);

    // R5 store, correct branch, register op
    iss(1, 0); iss(2, 0); iss(0, 9);
    post(m_next - 3 < 0 ? m_next + 5 : m_next - 3, 32'h55, 32'h100, 0, 0);
    post(m_next - 2 < 0 ? m_next + 6 : m_next - 2, 32'h0, 32'h40, 0, 0);
    post(m_next - 1 < 0 ? m_next + 7 : m_next - 1, 32'h99, 0, 0, 0);
    idle(5);

    // R7 fault held behind older entry, then R9 flush ignores issue and result
    idle(1);
    iss(0, 1); iss(0, 2); iss(0, 3);
    post((m_next + 6) % DEPTH, 32'hbad, 0, 1, 0);
    idle(2);
    post((m_next + 5) % DEPTH, 32'h1, 0, 0, 0);
    idle(1);
    run(1, 0, 4, 1, (m_next + 7) % DEPTH, 32'h3, 0, 0, 0, (m_next + 7) % DEPTH, "R9");
    chk("R9", "tag after flush", iss_tag, 0);
    idle(2);

    // R8 mispredicted branch at the head
    iss(2, 0); iss(0, 6);
    post(1, 32'h7, 0, 0, 0);
    post(0, 32'h0, 32'h2000, 0, 1);
    idle(3);

    // R10 sustained dispatch with retirement every cycle
    iss(0, 2);
    for (int i = 0; i < 12; i++)
      run(1, 0, i, 1, (m_next + DEPTH - 1) % DEPTH, 32'h300 + i, 0, 0, 0, (m_next + DEPTH - 1) % DEPTH, "R6");
    idle(3);

    // random traffic
    for (int i = 0; i < 3000; i++)
      run($urandom % 2, $urandom % 3, $urandom % 32, $urandom % 2, $urandom % DEPTH,
          $urandom, $urandom, ($urandom % 16) == 0, ($urandom % 4) == 0, $urandom % DEPTH, "R6");
    idle(12);
    finish_up();
  end
endmodule